// File: doc/BRIEF.md
# Three-Phase PWM Emergency Shutdown Controller

This block sits between a three-phase PWM generator and the six motor pads: the high and low sides of the U, V and W phases. It watches an active-low trip input. The trip is first synchronized and then optionally cleaned by a sampling filter. When the cleaned level is low while motor mode is on, the block clears the PWM output-enable flag and keeps it cleared.

During a trip the pads do one of two things, chosen by a software-written cutoff-mode bit:

- With the bit set, every pad floats together, whatever function the pad currently serves.
- With the bit clear, every pad returns to its general-purpose or alternate-peripheral path.

Software re-arms the output by writing 1 to the enable flag. That write is refused while the cleaned trip level is still low, so software reads the flag back and retries. Each pad has a registered output value and output-enable. The pad driver applies them, and an output-enable of 0 means high impedance.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: Reset clears the enable flag and the cutoff-mode bit, presets the cleaned trip level high, and drives every pad_oe and pad_out bit to 0.
- R2: When filt_sel is 0, the trip input passes through a two-flop synchronizer into the cleaned-level register. Pads respond at the fourth rising edge after a change on trip_n, and a low pulse of two clock cycles is enough to trip.
- R3: When filt_sel is non-zero, the synchronized input is sampled only on cycles with samp_en high. The cleaned level changes only after three consecutive equal samples. With samp_en held high, pads respond at the seventh rising edge after a change, and a two-cycle low pulse is ignored.
- R4: While motor_mode is 1 and the cleaned level is low, the enable flag becomes 0 and is held at 0 on every cycle.
- R5: A write of 1 to the enable flag takes effect only when the cleaned level is high. Otherwise the flag stays 0.
- R6: With the cutoff-mode bit at 1 and the cleaned level low, every pad has pad_oe=0 and pad_out=0, regardless of motor_mode, the enable flag or the alternate direction bits.
- R7: With the cutoff-mode bit at 0 and the cleaned level low, each pad carries pad_out=alt_out and pad_oe=alt_dir.
- R8: With motor_mode=1, the enable flag at 1 and the cleaned level high, pad_out=pwm_in and every pad_oe bit is 1, for either value of the cutoff-mode bit.
- R9: With the cleaned level high but motor_mode=0 or the enable flag at 0, pads carry pad_out=alt_out and pad_oe=alt_dir.
- R10: A write of 0 to the enable flag always clears it.

Pad mapping, bit 0 to bit 5, is U, U-bar, V, V-bar, W, W-bar. Pad registers update one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_n | input | 1 | Asynchronous active-low shutdown request |
| filt_sel | input | 3 | Filter select: 0 means bypass, non-zero enables the three-sample filter |
| samp_en | input | 1 | Filter sampling strobe, one clock wide |
| motor_mode | input | 1 | Motor-timer mode is on |
| cut_wr | input | 1 | Write strobe for the cutoff-mode bit |
| cut_wdata | input | 1 | Value written to the cutoff-mode bit |
| en_wr | input | 1 | Write strobe for the enable flag |
| en_wdata | input | 1 | Value written to the enable flag |
| en_flag | output | 1 | Current PWM output-enable flag (readback) |
| pwm_in | input | 6 | PWM generator outputs |
| alt_out | input | 6 | Fallback output values |
| alt_dir | input | 6 | Fallback direction bits (1 means drive) |
| pad_out | output | 6 | Registered pad output value |
| pad_oe | output | 6 | Registered pad output-enable (0 means high impedance) |

## Verification
The bench builds the block with its default parameters: six pads, a two-flop synchronizer and three-sample agreement. This keeps every pad-selection case small enough to enumerate. It sweeps all combinations of cutoff mode, motor mode and trip level under several PWM and fallback patterns. For each combination it attempts a re-arm and compares the flag and every pad against a model. Edge-exact checks pin down the four-edge bypass latency and the seven-edge filtered latency, and short pulses show the difference between catching a glitch and rejecting it.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  typedef enum logic [1:0] {
    PAD_ALT = 2'd0,
    PAD_PWM = 2'd1,
    PAD_HIZ = 2'd2
  } pad_sel_e;
endpackage

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip_n,
  input  logic [SEL_W-1:0] filt_sel,
  input  logic             samp_en,
  output logic             lvl_hi
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] samp_q;
  logic                filt_on;
  logic                all_hi, all_lo;

  assign filt_on = |filt_sel;
  assign all_hi  = &samp_q;
  assign all_lo  = ~|samp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      samp_q <= '1;
      lvl_hi <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], trip_n};
      if (samp_en)
        samp_q <= {samp_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (!filt_on)
        lvl_hi <= sync_q[SYNC_LEN-1];
      else if (all_hi)
        lvl_hi <= 1'b1;
      else if (all_lo)
        lvl_hi <= 1'b0;
    end
  end

  // R3: a mixed sample window never moves the cleaned level
  a_r3_mixed_holds: assert property (@(posedge clk) disable iff (rst)
    (filt_on && !all_hi && !all_lo) |=> $stable(lvl_hi));
endmodule

// File: rtl/trip_enable.sv
module trip_enable (
  input  logic clk,
  input  logic rst,
  input  logic lvl_hi,
  input  logic motor_mode,
  input  logic en_wr,
  input  logic en_wdata,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)
      en_q <= 1'b0;
    else if (motor_mode && !lvl_hi)
      en_q <= 1'b0;
    else if (en_wr)
      en_q <= en_wdata & lvl_hi;
  end

  // R4: a trip in motor mode leaves the flag clear
  a_r4_trip_clears: assert property (@(posedge clk) disable iff (rst)
    (motor_mode && !lvl_hi) |=> !en_q);
  // R5: arming is refused while the trip is low
  a_r5_arm_refused: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_wdata && !lvl_hi && !en_q) |=> !en_q);
  // R10: writing zero always clears
  a_r10_write_zero: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_wdata) |=> !en_q);
endmodule

// File: rtl/pad_mux.sv
module pad_mux
  import pwm_trip_pkg::*;
#(
  parameter int NUM_PADS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  pad_sel_e            sel,
  input  logic [NUM_PADS-1:0] pwm_in,
  input  logic [NUM_PADS-1:0] alt_out,
  input  logic [NUM_PADS-1:0] alt_dir,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        unique case (sel)
          PAD_PWM: begin pad_out[i] <= pwm_in[i];  pad_oe[i] <= 1'b1;       end
          PAD_HIZ: begin pad_out[i] <= 1'b0;       pad_oe[i] <= 1'b0;       end
          default: begin pad_out[i] <= alt_out[i]; pad_oe[i] <= alt_dir[i]; end
        endcase
      end
    end
  end

  // R6: every pad floats together
  a_r6_all_float: assert property (@(posedge clk) disable iff (rst)
    (sel == PAD_HIZ) |=> (pad_oe == '0 && pad_out == '0));
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_PADS = 6,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trip_n,
  input  logic [SEL_W-1:0]    filt_sel,
  input  logic                samp_en,
  input  logic                motor_mode,
  input  logic                cut_wr,
  input  logic                cut_wdata,
  input  logic                en_wr,
  input  logic                en_wdata,
  output logic                en_flag,
  input  logic [NUM_PADS-1:0] pwm_in,
  input  logic [NUM_PADS-1:0] alt_out,
  input  logic [NUM_PADS-1:0] alt_dir,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  logic     lvl_hi;
  logic     cut_q;
  pad_sel_e sel;

  trip_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN), .SEL_W(SEL_W)) u_filt (
    .clk(clk), .rst(rst), .trip_n(trip_n), .filt_sel(filt_sel),
    .samp_en(samp_en), .lvl_hi(lvl_hi)
  );

  trip_enable u_en (
    .clk(clk), .rst(rst), .lvl_hi(lvl_hi), .motor_mode(motor_mode),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)         cut_q <= 1'b0;
    else if (cut_wr) cut_q <= cut_wdata;
  end

  always_comb begin
    if (cut_q && !lvl_hi)                     sel = PAD_HIZ;
    else if (motor_mode && en_flag && lvl_hi) sel = PAD_PWM;
    else                                      sel = PAD_ALT;
  end

  pad_mux #(.NUM_PADS(NUM_PADS)) u_mux (
    .clk(clk), .rst(rst), .sel(sel), .pwm_in(pwm_in), .alt_out(alt_out),
    .alt_dir(alt_dir), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R8: normal operation drives every pad from the generator
  a_r8_pwm_drive: assert property (@(posedge clk) disable iff (rst)
    (motor_mode && en_flag && lvl_hi) |=> (pad_oe == '1 && pad_out == $past(pwm_in)));
  // R7: non-floating trip releases the pads to the fallback path
  a_r7_fallback: assert property (@(posedge clk) disable iff (rst)
    (!cut_q && !lvl_hi) |=> (pad_oe == $past(alt_dir) && pad_out == $past(alt_out)));
endmodule

// File: tb/pwm_trip_ctrl_test.sv
module pwm_trip_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_n = 1'b1;
  logic [2:0] filt_sel = 3'd0;
  logic samp_en = 1'b1;
  logic motor_mode = 1'b0;
  logic cut_wr = 1'b0, cut_wdata = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic en_flag;
  logic [NP-1:0] pwm_in = '0, alt_out = '0, alt_dir = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_ctrl uut (
    .clk(clk), .rst(rst), .trip_n(trip_n), .filt_sel(filt_sel), .samp_en(samp_en),
    .motor_mode(motor_mode), .cut_wr(cut_wr), .cut_wdata(cut_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_flag(en_flag),
    .pwm_in(pwm_in), .alt_out(alt_out), .alt_dir(alt_dir),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cut(input logic v);
    cut_wr = 1'b1; cut_wdata = v; step(1); cut_wr = 1'b0;
  endtask

  task automatic write_en(input logic v);
    en_wr = 1'b1; en_wdata = v; step(1); en_wr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
  end

  initial begin
    // wait until reset has been released
    step(2);
    chk("R1 en", en_flag, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 out", pad_out, 0);

    // R1: the cutoff-mode bit resets to 0, so a trip releases the pads to fallback
    alt_out = 6'h15; alt_dir = 6'h33; pwm_in = 6'h2C;
    trip_n = 1'b0; step(6);
    chk("R1 cut reset out", pad_out, 6'h15);
    chk("R1 cut reset oe", pad_oe, 6'h33);
    trip_n = 1'b1; step(6);

    // full sweep
    for (int pat = 0; pat < 4; pat++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 2; m++)
          for (int l = 0; l < 2; l++) begin
            logic [NP-1:0] eo, eoe;
            logic ee;
            pwm_in  = NP'(pat * 13 + 5);
            alt_out = NP'(pat * 23) ^ 6'h2A;
            alt_dir = NP'(pat * 7 + 9);
            set_cut(c[0]);
            motor_mode = m[0];
            trip_n = l[0];
            step(8);
            write_en(1'b1);
            step(3);
            ee = l[0];
            chk(l[0] ? "R5 arm accepted" : "R4/R5 arm refused", en_flag, ee);
            if (c[0] && !l[0]) begin
              eo = '0; eoe = '0;           // R6
            end else if (m[0] && ee && l[0]) begin
              eo = pwm_in; eoe = '1;       // R8
            end else begin
              eo = alt_out; eoe = alt_dir; // R7/R9
            end
            chk(c[0] && !l[0] ? "R6 out" : (m[0] && l[0]) ? "R8 out" : "R7/R9 out", pad_out, eo);
            chk(c[0] && !l[0] ? "R6 oe" : (m[0] && l[0]) ? "R8 oe" : "R7/R9 oe", pad_oe, eoe);
          end

    // R10: writing 0 clears the flag
    trip_n = 1'b1; motor_mode = 1'b1; set_cut(1'b1); step(8);
    write_en(1'b1); step(2);
    chk("R10 precondition", en_flag, 1);
    write_en(1'b0); step(2);
    chk("R10 cleared", en_flag, 0);
    chk("R10 pads fallback", pad_oe, alt_dir);

    // R2: bypass latency, four edges
    write_en(1'b1); step(3);
    trip_n = 1'b0;
    step(3);
    chk("R2 before edge 4", pad_oe, 6'h3F);
    step(1);
    chk("R2 at edge 4", pad_oe, 0);
    chk("R4 flag cleared", en_flag, 0);
    // R4: the trip keeps the flag held at 0
    write_en(1'b1); step(2);
    chk("R4 held", en_flag, 0);
    trip_n = 1'b1; step(8);

    // R2: a two-cycle pulse trips in bypass
    write_en(1'b1); step(3);
    chk("R2 armed", en_flag, 1);
    trip_n = 1'b0; step(2); trip_n = 1'b1; step(8);
    chk("R2 short pulse trips", en_flag, 0);

    // R3: filtered latency, seven edges with samp_en high
    filt_sel = 3'd4; samp_en = 1'b1; step(8);
    write_en(1'b1); step(3);
    trip_n = 1'b0;
    step(6);
    chk("R3 before edge 7", pad_oe, 6'h3F);
    step(1);
    chk("R3 at edge 7", pad_oe, 0);
    trip_n = 1'b1; step(10);

    // R3: a two-cycle pulse is rejected
    write_en(1'b1); step(3);
    trip_n = 1'b0; step(2); trip_n = 1'b1; step(10);
    chk("R3 glitch rejected", en_flag, 1);
    chk("R3 glitch pads", pad_oe, 6'h3F);

    // R3: no sampling strobe, no level change
    samp_en = 1'b0;
    trip_n = 1'b0; step(20);
    chk("R3 no strobe", en_flag, 1);
    chk("R3 no strobe pads", pad_out, pwm_in);
    samp_en = 1'b1; step(8);
    chk("R3 strobe resumes trip", pad_oe, 0);
    trip_n = 1'b1; step(10);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule